// File: doc/BRIEF.md
# Paired-Page TLB Lookup Unit

A fully associative address translation cache. Each of its entries describes two neighbouring virtual pages, an even one and an odd one, whose size is set per entry by a page mask. A lookup presents a virtual address, an access kind (load, store or instruction fetch) and the current address-space identifier. Every entry is compared in parallel, and in the same cycle the unit answers with either a physical address plus read/write permission or a fault code.

Entries are loaded through a registered write port that takes an index and all entry fields at once. The surrounding core owns refill choice, table walking and exception entry; this block only translates and classifies.

Top module: `tlb_pair_lookup`

## Requirements
- R1: After reset no entry can match, so every lookup returns NOMATCH with `lk_pa`, `lk_rd` and `lk_wr` all zero.
- R2: An entry matches only when its hardware-invalidate flag is clear, its masked virtual page equals the masked address, and either its global flag is set or its stored ASID equals `lk_asid`.
- R3: The compare mask is the entry's page mask ORed with all bits below bit PAGE_SHIFT+1. Address bits under that mask, and stored page bits under it, take no part in the compare. The highest set bit of the compare mask selects the odd half (1) or the even half (0).
- R4: On success `lk_pa` is the selected half's frame number shifted left by PAGE_SHIFT, ORed with the address bits below the half-select bit.
- R5: A match on a half whose valid bit is clear reports INVALID, whatever the access kind and the inhibit bits.
- R6: A fetch (`lk_kind`=2) on a valid half with its execute-inhibit bit set reports XI. Loads and stores ignore that bit.
- R7: A load (`lk_kind`=0) on a valid half with its read-inhibit bit set and no XI condition reports RI. Fetches and stores ignore that bit.
- R8: A store (`lk_kind`=1) on a valid half whose dirty bit is clear reports DIRTY.
- R9: On MATCH, `lk_rd` is 1 and `lk_wr` equals the selected half's dirty bit, for every access kind. On any other code, `lk_rd`, `lk_wr` and `lk_pa` are 0.
- R10: When several entries match, the lowest-indexed one decides the result.
- R11: A write with `wr_en` high changes only entry `wr_idx`, and only from the clock edge that samples it. Before that edge, the lookup still reflects the old contents.
- R12: `lk_code` is 4-bit two's complement: MATCH=0, NOMATCH=-2 (0xE), INVALID=-3 (0xD), DIRTY=-4 (0xC), RI=-5 (0xB), XI=-6 (0xA). The value -1 (bad address) is reserved and never produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write entry `wr_idx` at the next edge |
| wr_idx | input | 4 | Entry index to write |
| wr_vpn | input | 32 | Virtual page address of the pair |
| wr_mask | input | 32 | Page mask (ones widen the page) |
| wr_asid | input | 8 | Address-space identifier of the entry |
| wr_global | input | 1 | Entry matches any ASID |
| wr_hinv | input | 1 | Hardware-invalidate flag (entry never matches) |
| wr_pfn_even | input | 20 | Frame number of the even half |
| wr_pfn_odd | input | 20 | Frame number of the odd half |
| wr_valid | input | 2 | Valid bits, bit 0 even half, bit 1 odd half |
| wr_dirty | input | 2 | Dirty (writable) bits, per half |
| wr_rinh | input | 2 | Read-inhibit bits, per half |
| wr_xinh | input | 2 | Execute-inhibit bits, per half |
| lk_va | input | 32 | Virtual address to translate |
| lk_kind | input | 2 | 0 load, 1 store, 2 fetch (3 unused) |
| lk_asid | input | 8 | Current address-space identifier |
| lk_code | output | 4 | Result code (see R12) |
| lk_pa | output | 32 | Physical address on MATCH, else 0 |
| lk_rd | output | 1 | Read permitted |
| lk_wr | output | 1 | Write permitted |

## Verification
The bench builds the unit with its defaults: 16 entries, 32-bit virtual and physical addresses, 4 KiB minimum pages and an 8-bit ASID. With 16 entries it can write the last index as well as overlapping entries at low indices, so the lowest-index rule is tested. A 32-bit address leaves room for a 64 KiB page pair with junk in its low page bits next to plain 4 KiB pairs. Each fault code is reached with its neighbouring priority conditions also present.

// File: rtl/tlbp_pkg.sv
package tlbp_pkg;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2
  } acc_kind_e;

  localparam logic [3:0] RC_MATCH   = 4'h0;
  localparam logic [3:0] RC_BADADDR = 4'hF;
  localparam logic [3:0] RC_NOMATCH = 4'hE;
  localparam logic [3:0] RC_INVALID = 4'hD;
  localparam logic [3:0] RC_DIRTY   = 4'hC;
  localparam logic [3:0] RC_RINH    = 4'hB;
  localparam logic [3:0] RC_XINH    = 4'hA;

endpackage

// File: rtl/tlbp_store.sv
module tlbp_store #(
  parameter int N      = 16,
  parameter int VA_W   = 32,
  parameter int ASID_W = 8,
  parameter int PFN_W  = 20,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [VA_W-1:0]   wr_vpn,
  input  logic [VA_W-1:0]   wr_mask,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic              wr_global,
  input  logic              wr_hinv,
  input  logic [PFN_W-1:0]  wr_pfn_even,
  input  logic [PFN_W-1:0]  wr_pfn_odd,
  input  logic [1:0]        wr_valid,
  input  logic [1:0]        wr_dirty,
  input  logic [1:0]        wr_rinh,
  input  logic [1:0]        wr_xinh,
  output logic [VA_W-1:0]   e_vpn   [N],
  output logic [VA_W-1:0]   e_mask  [N],
  output logic [ASID_W-1:0] e_asid  [N],
  output logic              e_glob  [N],
  output logic              e_hinv  [N],
  output logic [PFN_W-1:0]  e_pfn0  [N],
  output logic [PFN_W-1:0]  e_pfn1  [N],
  output logic [1:0]        e_valid [N],
  output logic [1:0]        e_dirty [N],
  output logic [1:0]        e_rinh  [N],
  output logic [1:0]        e_xinh  [N]
);

  for (genvar i = 0; i < N; i++) begin : g_ent
    logic              load_en;
    logic [VA_W-1:0]   vpn_q, mask_q;
    logic [ASID_W-1:0] asid_q;
    logic              glob_q, hinv_q;
    logic [PFN_W-1:0]  pfn0_q, pfn1_q;
    logic [1:0]        valid_q, dirty_q, rinh_q, xinh_q;

    always_comb begin
      load_en = wr_en && (wr_idx == IDX_W'(i));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vpn_q   <= '0;
        mask_q  <= '0;
        asid_q  <= '0;
        glob_q  <= 1'b0;
        hinv_q  <= 1'b1;
        pfn0_q  <= '0;
        pfn1_q  <= '0;
        valid_q <= '0;
        dirty_q <= '0;
        rinh_q  <= '0;
        xinh_q  <= '0;
      end else if (load_en) begin
        vpn_q   <= wr_vpn;
        mask_q  <= wr_mask;
        asid_q  <= wr_asid;
        glob_q  <= wr_global;
        hinv_q  <= wr_hinv;
        pfn0_q  <= wr_pfn_even;
        pfn1_q  <= wr_pfn_odd;
        valid_q <= wr_valid;
        dirty_q <= wr_dirty;
        rinh_q  <= wr_rinh;
        xinh_q  <= wr_xinh;
      end
    end

    assign e_vpn[i]   = vpn_q;
    assign e_mask[i]  = mask_q;
    assign e_asid[i]  = asid_q;
    assign e_glob[i]  = glob_q;
    assign e_hinv[i]  = hinv_q;
    assign e_pfn0[i]  = pfn0_q;
    assign e_pfn1[i]  = pfn1_q;
    assign e_valid[i] = valid_q;
    assign e_dirty[i] = dirty_q;
    assign e_rinh[i]  = rinh_q;
    assign e_xinh[i]  = xinh_q;
  end

endmodule

// File: rtl/tlbp_cmp.sv
module tlbp_cmp #(
  parameter int VA_W       = 32,
  parameter int PA_W       = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int ASID_W     = 8,
  localparam int PFN_W     = PA_W - PAGE_SHIFT
) (
  input  logic [VA_W-1:0]   va,
  input  logic [ASID_W-1:0] cur_asid,
  input  logic [VA_W-1:0]   vpn,
  input  logic [VA_W-1:0]   pmask,
  input  logic [ASID_W-1:0] asid,
  input  logic              glob,
  input  logic              hinv,
  input  logic [PFN_W-1:0]  pfn0,
  input  logic [PFN_W-1:0]  pfn1,
  input  logic [1:0]        valid,
  input  logic [1:0]        dirty,
  input  logic [1:0]        rinh,
  input  logic [1:0]        xinh,
  output logic              hit,
  output logic [PA_W-1:0]   pa,
  output logic              h_valid,
  output logic              h_dirty,
  output logic              h_rinh,
  output logic              h_xinh
);

  localparam logic [VA_W-1:0] PAIR_MASK =
    VA_W'((64'd1 << (PAGE_SHIFT + 1)) - 64'd1);

  logic [VA_W-1:0] cmask;
  logic [VA_W-1:0] half_bit;
  logic [VA_W-1:0] offs;
  logic            odd;
  logic [PFN_W-1:0] pfn_sel;

  always_comb begin
    cmask    = pmask | PAIR_MASK;
    half_bit = cmask & ~(cmask >> 1);
    offs     = va & (cmask >> 1);
    odd      = |(va & half_bit);
    hit      = !hinv && (glob || (asid == cur_asid)) &&
               ((va & ~cmask) == (vpn & ~cmask));
    pfn_sel  = odd ? pfn1 : pfn0;
    pa       = {pfn_sel, {PAGE_SHIFT{1'b0}}} | PA_W'(offs);
    h_valid  = valid[odd];
    h_dirty  = dirty[odd];
    h_rinh   = rinh[odd];
    h_xinh   = xinh[odd];
  end

endmodule

// File: rtl/tlbp_resolve.sv
module tlbp_resolve
  import tlbp_pkg::*;
#(
  parameter int N    = 16,
  parameter int PA_W = 32
) (
  input  logic [N-1:0]    hit,
  input  logic [PA_W-1:0] pa      [N],
  input  logic [N-1:0]    h_valid,
  input  logic [N-1:0]    h_dirty,
  input  logic [N-1:0]    h_rinh,
  input  logic [N-1:0]    h_xinh,
  input  acc_kind_e       kind,
  output logic [3:0]      code,
  output logic [PA_W-1:0] pa_out,
  output logic            rd,
  output logic            wr
);

  logic            any;
  logic [PA_W-1:0] w_pa;
  logic            w_v, w_d, w_r, w_x;

  // Scan from the top so the lowest matching index is written last.
  always_comb begin
    any  = 1'b0;
    w_pa = '0;
    w_v  = 1'b0;
    w_d  = 1'b0;
    w_r  = 1'b0;
    w_x  = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit[i]) begin
        any  = 1'b1;
        w_pa = pa[i];
        w_v  = h_valid[i];
        w_d  = h_dirty[i];
        w_r  = h_rinh[i];
        w_x  = h_xinh[i];
      end
    end
  end

  always_comb begin
    code   = RC_MATCH;
    pa_out = '0;
    rd     = 1'b0;
    wr     = 1'b0;
    if (!any) begin
      code = RC_NOMATCH;
    end else if (!w_v) begin
      code = RC_INVALID;
    end else if (kind == ACC_FETCH && w_x) begin
      code = RC_XINH;
    end else if (kind == ACC_LOAD && w_r) begin
      code = RC_RINH;
    end else if (kind == ACC_STORE && !w_d) begin
      code = RC_DIRTY;
    end else begin
      pa_out = w_pa;
      rd     = 1'b1;
      wr     = w_d;
    end
  end

endmodule

// File: rtl/tlb_pair_lookup.sv
module tlb_pair_lookup
  import tlbp_pkg::*;
#(
  parameter int N          = 16,
  parameter int VA_W       = 32,
  parameter int PA_W       = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int ASID_W     = 8,
  localparam int IDX_W     = (N > 1) ? $clog2(N) : 1,
  localparam int PFN_W     = PA_W - PAGE_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [VA_W-1:0]   wr_vpn,
  input  logic [VA_W-1:0]   wr_mask,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic              wr_global,
  input  logic              wr_hinv,
  input  logic [PFN_W-1:0]  wr_pfn_even,
  input  logic [PFN_W-1:0]  wr_pfn_odd,
  input  logic [1:0]        wr_valid,
  input  logic [1:0]        wr_dirty,
  input  logic [1:0]        wr_rinh,
  input  logic [1:0]        wr_xinh,
  input  logic [VA_W-1:0]   lk_va,
  input  logic [1:0]        lk_kind,
  input  logic [ASID_W-1:0] lk_asid,
  output logic [3:0]        lk_code,
  output logic [PA_W-1:0]   lk_pa,
  output logic              lk_rd,
  output logic              lk_wr
);

  logic [VA_W-1:0]   e_vpn   [N];
  logic [VA_W-1:0]   e_mask  [N];
  logic [ASID_W-1:0] e_asid  [N];
  logic              e_glob  [N];
  logic              e_hinv  [N];
  logic [PFN_W-1:0]  e_pfn0  [N];
  logic [PFN_W-1:0]  e_pfn1  [N];
  logic [1:0]        e_valid [N];
  logic [1:0]        e_dirty [N];
  logic [1:0]        e_rinh  [N];
  logic [1:0]        e_xinh  [N];

  logic [N-1:0]    hit, h_valid, h_dirty, h_rinh, h_xinh;
  logic [PA_W-1:0] ent_pa [N];

  tlbp_store #(
    .N(N), .VA_W(VA_W), .ASID_W(ASID_W), .PFN_W(PFN_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_vpn(wr_vpn), .wr_mask(wr_mask), .wr_asid(wr_asid),
    .wr_global(wr_global), .wr_hinv(wr_hinv),
    .wr_pfn_even(wr_pfn_even), .wr_pfn_odd(wr_pfn_odd),
    .wr_valid(wr_valid), .wr_dirty(wr_dirty), .wr_rinh(wr_rinh),
    .wr_xinh(wr_xinh),
    .e_vpn(e_vpn), .e_mask(e_mask), .e_asid(e_asid), .e_glob(e_glob),
    .e_hinv(e_hinv), .e_pfn0(e_pfn0), .e_pfn1(e_pfn1),
    .e_valid(e_valid), .e_dirty(e_dirty), .e_rinh(e_rinh),
    .e_xinh(e_xinh)
  );

  for (genvar i = 0; i < N; i++) begin : g_cmp
    tlbp_cmp #(
      .VA_W(VA_W), .PA_W(PA_W), .PAGE_SHIFT(PAGE_SHIFT), .ASID_W(ASID_W)
    ) u_cmp (
      .va(lk_va), .cur_asid(lk_asid),
      .vpn(e_vpn[i]), .pmask(e_mask[i]), .asid(e_asid[i]),
      .glob(e_glob[i]), .hinv(e_hinv[i]),
      .pfn0(e_pfn0[i]), .pfn1(e_pfn1[i]),
      .valid(e_valid[i]), .dirty(e_dirty[i]),
      .rinh(e_rinh[i]), .xinh(e_xinh[i]),
      .hit(hit[i]), .pa(ent_pa[i]),
      .h_valid(h_valid[i]), .h_dirty(h_dirty[i]),
      .h_rinh(h_rinh[i]), .h_xinh(h_xinh[i])
    );
  end

  tlbp_resolve #(.N(N), .PA_W(PA_W)) u_res (
    .hit(hit), .pa(ent_pa), .h_valid(h_valid), .h_dirty(h_dirty),
    .h_rinh(h_rinh), .h_xinh(h_xinh), .kind(acc_kind_e'(lk_kind)),
    .code(lk_code), .pa_out(lk_pa), .rd(lk_rd), .wr(lk_wr)
  );

endmodule

// File: rtl/tlb_pair_lookup_chk.sv
module tlb_pair_lookup_chk #(
  parameter int VA_W   = 32,
  parameter int PA_W   = 32,
  parameter int ASID_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [VA_W-1:0]   lk_va,
  input logic [1:0]        lk_kind,
  input logic [ASID_W-1:0] lk_asid,
  input logic [3:0]        lk_code,
  input logic [PA_W-1:0]   lk_pa,
  input logic              lk_rd,
  input logic              lk_wr
);

  // R9
  fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_code != 4'h0) |-> (!lk_rd && !lk_wr && lk_pa == '0));

  // R9
  match_reads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_code == 4'h0) |-> lk_rd);

  // R12
  legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_code == 4'h0 || lk_code == 4'hE || lk_code == 4'hD ||
     lk_code == 4'hC || lk_code == 4'hB || lk_code == 4'hA));

  // R6
  xinh_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_code == 4'hA) |-> (lk_kind == 2'd2));

  // R7
  rinh_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_code == 4'hB) |-> (lk_kind == 2'd0));

  // R8
  dirty_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_code == 4'hC) |-> (lk_kind == 2'd1));

  // R11
  hold_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!wr_en) && $stable(lk_va) && $stable(lk_kind) &&
     $stable(lk_asid)) |-> ($stable(lk_code) && $stable(lk_pa)));

endmodule

bind tlb_pair_lookup tlb_pair_lookup_chk #(
  .VA_W(VA_W), .PA_W(PA_W), .ASID_W(ASID_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .lk_va(lk_va),
  .lk_kind(lk_kind), .lk_asid(lk_asid), .lk_code(lk_code),
  .lk_pa(lk_pa), .lk_rd(lk_rd), .lk_wr(lk_wr)
);

// File: tb/sim_tlb_pair_lookup.sv
module sim_tlb_pair_lookup;

  localparam logic [3:0] C_OK  = 4'h0;
  localparam logic [3:0] C_NM  = 4'hE;
  localparam logic [3:0] C_INV = 4'hD;
  localparam logic [3:0] C_DRT = 4'hC;
  localparam logic [3:0] C_RI  = 4'hB;
  localparam logic [3:0] C_XI  = 4'hA;
  localparam logic [1:0] K_LD = 2'd0, K_ST = 2'd1, K_FE = 2'd2;

  logic        clk, rst_n;
  logic        wr_en, wr_global, wr_hinv;
  logic [3:0]  wr_idx;
  logic [31:0] wr_vpn, wr_mask, lk_va, lk_pa;
  logic [7:0]  wr_asid, lk_asid;
  logic [19:0] wr_pfn_even, wr_pfn_odd;
  logic [1:0]  wr_valid, wr_dirty, wr_rinh, wr_xinh, lk_kind;
  logic [3:0]  lk_code;
  logic        lk_rd, lk_wr;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  tlb_pair_lookup u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_vpn(wr_vpn), .wr_mask(wr_mask), .wr_asid(wr_asid),
    .wr_global(wr_global), .wr_hinv(wr_hinv),
    .wr_pfn_even(wr_pfn_even), .wr_pfn_odd(wr_pfn_odd),
    .wr_valid(wr_valid), .wr_dirty(wr_dirty), .wr_rinh(wr_rinh),
    .wr_xinh(wr_xinh), .lk_va(lk_va), .lk_kind(lk_kind),
    .lk_asid(lk_asid), .lk_code(lk_code), .lk_pa(lk_pa),
    .lk_rd(lk_rd), .lk_wr(lk_wr)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(string tag, logic [3:0] ec, logic [31:0] epa,
                       logic erd, logic ewr);
    checks++;
    if (lk_code !== ec || lk_pa !== epa || lk_rd !== erd || lk_wr !== ewr) begin
      errors++;
      $display("FAIL %s: got code=%h pa=%h rd=%b wr=%b, want code=%h pa=%h rd=%b wr=%b",
               tag, lk_code, lk_pa, lk_rd, lk_wr, ec, epa, erd, ewr);
    end
  endtask

  task automatic set_wr(logic [3:0] idx, logic [31:0] vpn, logic [31:0] msk,
                        logic [7:0] asid, logic g, logic hi,
                        logic [19:0] p0, logic [19:0] p1, logic [1:0] v,
                        logic [1:0] d, logic [1:0] ri, logic [1:0] xi);
    wr_idx = idx; wr_vpn = vpn; wr_mask = msk; wr_asid = asid;
    wr_global = g; wr_hinv = hi; wr_pfn_even = p0; wr_pfn_odd = p1;
    wr_valid = v; wr_dirty = d; wr_rinh = ri; wr_xinh = xi;
  endtask

  task automatic write_ent(logic [3:0] idx, logic [31:0] vpn, logic [31:0] msk,
                           logic [7:0] asid, logic g, logic hi,
                           logic [19:0] p0, logic [19:0] p1, logic [1:0] v,
                           logic [1:0] d, logic [1:0] ri, logic [1:0] xi);
    @(negedge clk);
    set_wr(idx, vpn, msk, asid, g, hi, p0, p1, v, d, ri, xi);
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic look(logic [31:0] va, logic [1:0] kind, logic [7:0] asid);
    @(negedge clk);
    lk_va = va; lk_kind = kind; lk_asid = asid;
    #5;
  endtask

  task automatic t_reset;
    look(32'h0000_1000, K_LD, 8'd0);
    check("R1 reset low page", C_NM, 32'h0, 1'b0, 1'b0);
    look(32'h8000_0000, K_FE, 8'd0);
    check("R1 reset high page", C_NM, 32'h0, 1'b0, 1'b0);
  endtask

  task automatic t_basic;
    write_ent(4'd0, 32'h0040_0000, 32'h0, 8'd5, 1'b0, 1'b0,
              20'h12345, 20'h23456, 2'b11, 2'b01, 2'b00, 2'b00);
    look(32'h0040_0ABC, K_LD, 8'd5);
    check("R4 even pa, R9 wr from dirty", C_OK, 32'h1234_5ABC, 1'b1, 1'b1);
    look(32'h0040_1ABC, K_LD, 8'd5);
    check("R4 odd pa, R9 load clean no wr", C_OK, 32'h2345_6ABC, 1'b1, 1'b0);
    look(32'h0040_1000, K_ST, 8'd5);
    check("R8 store clean odd", C_DRT, 32'h0, 1'b0, 1'b0);
    look(32'h0040_0010, K_ST, 8'd5);
    check("R8 store dirty even", C_OK, 32'h1234_5010, 1'b1, 1'b1);
    look(32'h0040_0ABC, K_LD, 8'd6);
    check("R2 asid mismatch", C_NM, 32'h0, 1'b0, 1'b0);
    look(32'h0040_2000, K_LD, 8'd5);
    check("R3 outside pair", C_NM, 32'h0, 1'b0, 1'b0);
  endtask

  task automatic t_global_hinv;
    write_ent(4'd1, 32'h1000_0000, 32'h0, 8'd9, 1'b1, 1'b0,
              20'h00AAA, 20'h00BBB, 2'b11, 2'b11, 2'b00, 2'b00);
    look(32'h1000_0044, K_LD, 8'd3);
    check("R2 global any asid", C_OK, 32'h00AA_A044, 1'b1, 1'b1);
    // R11: write with hinv set is pending; old result before edge
    @(negedge clk);
    set_wr(4'd1, 32'h1000_0000, 32'h0, 8'd9, 1'b1, 1'b1,
           20'h00AAA, 20'h00BBB, 2'b11, 2'b11, 2'b00, 2'b00);
    wr_en = 1'b1;
    #5;
    check("R11 before edge old entry", C_OK, 32'h00AA_A044, 1'b1, 1'b1);
    @(posedge clk);
    #5;
    check("R2 hinv blocks match after edge", C_NM, 32'h0, 1'b0, 1'b0);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t_large;
    // 64 KiB pages: mask 0x0001E000, compare mask 0x1FFFF, select bit 16.
    // Stored vpn has junk in masked bits.
    write_ent(4'd2, 32'h2000_5000, 32'h0001_E000, 8'd1, 1'b0, 1'b0,
              20'h30000, 20'h40000, 2'b11, 2'b10, 2'b00, 2'b00);
    look(32'h2000_F345, K_LD, 8'd1);
    check("R3 large even", C_OK, 32'h3000_F345, 1'b1, 1'b0);
    look(32'h2001_8765, K_LD, 8'd1);
    check("R3 large odd R4", C_OK, 32'h4000_8765, 1'b1, 1'b1);
    look(32'h2002_0000, K_LD, 8'd1);
    check("R3 large outside pair", C_NM, 32'h0, 1'b0, 1'b0);
  endtask

  task automatic t_faults;
    write_ent(4'd3, 32'h5000_0000, 32'h0, 8'd7, 1'b0, 1'b0,
              20'h00111, 20'h00222, 2'b10, 2'b00, 2'b11, 2'b11);
    look(32'h5000_0000, K_FE, 8'd7);
    check("R5 invalid beats xi", C_INV, 32'h0, 1'b0, 1'b0);
    look(32'h5000_0008, K_ST, 8'd7);
    check("R5 invalid beats dirty", C_INV, 32'h0, 1'b0, 1'b0);
    look(32'h5000_1000, K_FE, 8'd7);
    check("R6 fetch xi", C_XI, 32'h0, 1'b0, 1'b0);
    look(32'h5000_1000, K_LD, 8'd7);
    check("R7 load ri", C_RI, 32'h0, 1'b0, 1'b0);
    look(32'h5000_1000, K_ST, 8'd7);
    check("R8 store clean with inhibits", C_DRT, 32'h0, 1'b0, 1'b0);
    write_ent(4'd4, 32'h6000_0000, 32'h0, 8'd7, 1'b0, 1'b0,
              20'h00333, 20'h00444, 2'b11, 2'b00, 2'b10, 2'b01);
    look(32'h6000_0020, K_LD, 8'd7);
    check("R6 xi ignored by load", C_OK, 32'h0033_3020, 1'b1, 1'b0);
    look(32'h6000_1030, K_FE, 8'd7);
    check("R7 ri ignored by fetch", C_OK, 32'h0044_4030, 1'b1, 1'b0);
  endtask

  task automatic t_priority;
    write_ent(4'd5, 32'h7000_0000, 32'h0, 8'd0, 1'b1, 1'b0,
              20'h00555, 20'h00556, 2'b11, 2'b11, 2'b00, 2'b00);
    write_ent(4'd6, 32'h7000_0000, 32'h0, 8'd0, 1'b1, 1'b0,
              20'h00666, 20'h00667, 2'b11, 2'b00, 2'b00, 2'b00);
    look(32'h7000_0100, K_LD, 8'd2);
    check("R10 lowest index wins", C_OK, 32'h0055_5100, 1'b1, 1'b1);
    write_ent(4'd5, 32'h7000_0000, 32'h0, 8'd0, 1'b1, 1'b1,
              20'h00555, 20'h00556, 2'b11, 2'b11, 2'b00, 2'b00);
    look(32'h7000_0100, K_LD, 8'd2);
    check("R10 next entry after hinv", C_OK, 32'h0066_6100, 1'b1, 1'b0);
    write_ent(4'd15, 32'h7F00_0000, 32'h0, 8'd0, 1'b1, 1'b0,
              20'h0FFF0, 20'h0FFF1, 2'b11, 2'b11, 2'b00, 2'b00);
    look(32'h7F00_1FFC, K_ST, 8'd0);
    check("R11 last index written", C_OK, 32'h0FFF_1FFC, 1'b1, 1'b1);
    look(32'h0040_0ABC, K_LD, 8'd5);
    check("R11 entry 0 untouched", C_OK, 32'h1234_5ABC, 1'b1, 1'b1);
    look(32'hFFFF_0000, K_LD, 8'd0);
    check("R12 unmapped code", C_NM, 32'h0, 1'b0, 1'b0);
  endtask

  task automatic report;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout, want completion");
      report();
    end
  end

  initial begin
    rst_n = 1'b0;
    wr_en = 1'b0;
    set_wr(4'd0, 32'h0, 32'h0, 8'd0, 1'b0, 1'b0, 20'h0, 20'h0,
           2'b00, 2'b00, 2'b00, 2'b00);
    lk_va = 32'h0; lk_kind = K_LD; lk_asid = 8'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_global_hinv();
    t_large();
    t_faults();
    t_priority();
    done = 1;
    report();
  end

endmodule